// File: doc/BRIEF.md
# RS-485 UART Transmitter with Driver-Enable Timing

This block serialises words onto a half-duplex RS-485 line and drives the line driver's enable output around each transmission. A word is offered on a valid/ready input. The block then raises the driver enable and waits a programmable lead time. It sends one low start bit, the data bits least significant first, and one high stop bit. It then holds the driver enable for a programmable lag time before releasing it and pulsing a completion flag. The lead and lag times are counted in clock cycles. Each bit lasts `CYC_PER_BIT` clock cycles.

The configuration port carries four fields: an enable bit, a two-bit word-length code, a 5-bit lead count and a 5-bit lag count. The three timing and format fields are frozen while the block is enabled. They load only from a write that has enable clear while the block is already disabled. The normal sequence is therefore one write to disable, one write to set the fields, and one write to enable. If a new word is waiting when a stop bit ends, its start bit follows at once. In that case the driver enable stays high and neither the lag nor the lead is inserted between the two frames.

The controller is a state machine with seven states. IDLE goes to LEAD when a word is accepted. LEAD goes to START when the lead count expires. START goes to DATA after one bit period. DATA stays in DATA from bit to bit and goes to STOP after the last data bit. STOP goes back to START when another word is accepted in its final cycle, and otherwise goes to LAG. LAG goes to DONE when the lag count expires. DONE always returns to IDLE after one cycle.

Top module: `rs485_uart_tx`

## Requirements
- R1: After reset, tx is 1, de is 0, tx_done is 0 and in_ready is 0. The configuration fields reset to zero, which means 8 data bits, lead 0 and lag 0.
- R2: The word-length code selects the number of data bits: 00 gives 8, 01 gives 9, 10 gives 7 and 11 gives 7. A frame is one start bit (0), the data bits sent from in_data bit 0 upward, and one stop bit (1). Each bit lasts CYC_PER_BIT cycles. in_data bits above the selected length are not sent.
- R3: de rises in the cycle after a word is accepted from IDLE. tx falls for the start bit exactly lead+1 cycles after de rises, for any lead value from 0 to 31.
- R4: After the last cycle of the final stop bit, de stays 1 for exactly lag+1 cycles and then falls, for any lag value from 0 to 31.
- R5: tx_done is 1 for exactly one cycle, which is the first cycle in which de is 0 after a frame.
- R6: A word that is accepted in the last cycle of a stop bit starts its start bit in the next cycle. de stays 1 and tx_done stays 0 between the two frames.
- R7: in_ready is 1 only while the block is enabled and either idle or in the last cycle of a stop bit.
- R8: A configuration write changes the word length, lead and lag only if the block is disabled and the write has enable 0. Any other write leaves these fields unchanged.
- R9: If enable is cleared during a frame, that frame still completes with its stop bit, lag and tx_done. A word that is waiting is not accepted, and in_ready stays 0 afterwards.
- R10: Whenever de is 0, tx is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmitter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable value to write |
| cfg_wlen | input | 2 | Word-length code to write |
| cfg_lead | input | 5 | Driver-enable lead count to write |
| cfg_lag | input | 5 | Driver-enable lag count to write |
| in_valid | input | 1 | A word is offered |
| in_data | input | 9 | Word to send; low bits are used first |
| in_ready | output | 1 | The offered word is taken at this clock edge |
| tx | output | 1 | Serial line, idles high |
| de | output | 1 | Line driver enable |
| tx_done | output | 1 | One-cycle pulse when de is released |

## Verification
The hardest case to reach from the ports is a handover in the single cycle at the end of a stop bit. The bench must have the next word already valid in that cycle, and the de and tx waveforms must show no gap. The stimulus keeps in_valid high with the next queued word from the moment the previous word is accepted, and it records every cycle of tx and de. Disabling during the data bits while a second word is still offered tests that same cycle from the other side. Full traces are compared against a waveform built arithmetically from the lead, lag, word length and bit period, over a sweep of all four length codes against extreme and middle delay values.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_LAG,
        ST_DONE
    } tx_state_e;

    // Two-bit length code to data-bit count.
    function automatic logic [3:0] wlen_bits(input logic [1:0] code);
        logic [3:0] n;
        unique case (code)
            2'b00:   n = 4'd8;
            2'b01:   n = 4'd9;
            default: n = 4'd7;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rs485_tx_cfg.sv
module rs485_tx_cfg #(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_en,
    input  logic [1:0]       wr_wlen,
    input  logic [DLY_W-1:0] wr_lead,
    input  logic [DLY_W-1:0] wr_lag,
    output logic             en_q,
    output logic [1:0]       wlen_q,
    output logic [DLY_W-1:0] lead_q,
    output logic [DLY_W-1:0] lag_q
);

    logic fields_open;

    // Fields load only while disabled and only from a write that keeps it disabled.
    assign fields_open = wr && !en_q && !wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            wlen_q <= '0;
            lead_q <= '0;
            lag_q  <= '0;
        end else begin
            if (wr) begin
                en_q <= wr_en;
            end
            if (fields_open) begin
                wlen_q <= wr_wlen;
                lead_q <= wr_lead;
                lag_q  <= wr_lag;
            end
        end
    end

endmodule

// File: rtl/rs485_tx_timer.sv
module rs485_tx_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/rs485_tx_shift.sv
module rs485_tx_shift #(
    parameter int WORD_W   = 9,
    parameter int BITCNT_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [WORD_W-1:0]   data,
    input  logic [BITCNT_W-1:0] nbits,
    input  logic                shift,
    output logic                bit_out,
    output logic                last
);

    logic [WORD_W-1:0]   sreg_q;
    logic [BITCNT_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            rem_q  <= '0;
        end else if (load) begin
            sreg_q <= data;
            rem_q  <= nbits;
        end else if (shift) begin
            sreg_q <= sreg_q >> 1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    assign bit_out = sreg_q[0];
    assign last    = (rem_q == BITCNT_W'(1));

endmodule

// File: rtl/rs485_uart_tx.sv
module rs485_uart_tx
    import rs485_tx_pkg::*;
#(
    parameter int CYC_PER_BIT = 4,
    parameter int DLY_W       = 5,
    parameter int WORD_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [1:0]        cfg_wlen,
    input  logic [DLY_W-1:0]  cfg_lead,
    input  logic [DLY_W-1:0]  cfg_lag,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx,
    output logic              de,
    output logic              tx_done
);

    localparam int DLY_MAX  = 1 << DLY_W;
    localparam int CNT_MAX  = (CYC_PER_BIT > DLY_MAX) ? CYC_PER_BIT : DLY_MAX;
    localparam int CNT_W    = $clog2(CNT_MAX);
    localparam int BITCNT_W = $clog2(WORD_W + 1);

    tx_state_e state_q, state_d;

    logic             cfg_en_q;
    logic [1:0]       cfg_wlen_q;
    logic [DLY_W-1:0] cfg_lead_q;
    logic [DLY_W-1:0] cfg_lag_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    logic             sh_load;
    logic             sh_shift;
    logic             sh_bit;
    logic             sh_last;

    logic [CNT_W-1:0]    bit_reload;
    logic [BITCNT_W-1:0] frame_bits;

    assign bit_reload = CNT_W'(CYC_PER_BIT - 1);
    assign frame_bits = BITCNT_W'(wlen_bits(cfg_wlen_q));

    rs485_tx_cfg #(.DLY_W(DLY_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wr_en   (cfg_en),
        .wr_wlen (cfg_wlen),
        .wr_lead (cfg_lead),
        .wr_lag  (cfg_lag),
        .en_q    (cfg_en_q),
        .wlen_q  (cfg_wlen_q),
        .lead_q  (cfg_lead_q),
        .lag_q   (cfg_lag_q)
    );

    rs485_tx_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    rs485_tx_shift #(.WORD_W(WORD_W), .BITCNT_W(BITCNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .data    (in_data),
        .nbits   (frame_bits),
        .shift   (sh_shift),
        .bit_out (sh_bit),
        .last    (sh_last)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions, handshake and datapath controls.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        in_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = cfg_en_q;
                if (cfg_en_q && in_valid) begin
                    state_d  = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(cfg_lead_q);
                    sh_load  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_zero) begin
                    state_d  = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = bit_reload;
                end
            end
            ST_START: begin
                if (tmr_zero) begin
                    state_d  = ST_DATA;
                    tmr_load = 1'b1;
                    tmr_val  = bit_reload;
                end
            end
            ST_DATA: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    tmr_val  = bit_reload;
                    if (sh_last) begin
                        state_d = ST_STOP;
                    end else begin
                        sh_shift = 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tmr_zero) begin
                    in_ready = cfg_en_q;
                    tmr_load = 1'b1;
                    if (cfg_en_q && in_valid) begin
                        state_d = ST_START;
                        tmr_val = bit_reload;
                        sh_load = 1'b1;
                    end else begin
                        state_d = ST_LAG;
                        tmr_val = CNT_W'(cfg_lag_q);
                    end
                end
            end
            ST_LAG: begin
                if (tmr_zero) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        tx      = 1'b1;
        de      = 1'b1;
        tx_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  de = 1'b0;
            ST_START: tx = 1'b0;
            ST_DATA:  tx = sh_bit;
            ST_DONE: begin
                de      = 1'b0;
                tx_done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rs485_uart_tx_chk.sv
module rs485_uart_tx_chk #(
    parameter int DLY_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx,
    input logic             de,
    input logic             tx_done,
    input logic             in_valid,
    input logic             in_ready,
    input logic             en_q,
    input logic [1:0]       wlen_q,
    input logic [DLY_W-1:0] lead_q,
    input logic [DLY_W-1:0] lag_q
);

    p_line_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> tx);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    p_done_at_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!de && $past(de)));

    p_start_under_de_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx) |-> (de && $past(de)));

    p_ready_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> en_q);

    p_accept_drives_de_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> de);

    p_fields_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> ($stable(wlen_q) && $stable(lead_q) && $stable(lag_q)));

endmodule

bind rs485_uart_tx rs485_uart_tx_chk #(.DLY_W(DLY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx       (tx),
    .de       (de),
    .tx_done  (tx_done),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .en_q     (cfg_en_q),
    .wlen_q   (cfg_wlen_q),
    .lead_q   (cfg_lead_q),
    .lag_q    (cfg_lag_q)
);

// File: tb/rs485_uart_tx_bench.sv
module rs485_uart_tx_bench;

    localparam int CPB = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr, cfg_en;
    logic [1:0] cfg_wlen;
    logic [4:0] cfg_lead, cfg_lag;
    logic       in_valid;
    logic [8:0] in_data;
    logic       in_ready, tx, de, tx_done;

    int total = 0;
    int bad   = 0;

    logic       tr_tx [512];
    logic       tr_de [512];
    logic       tr_dn [512];
    logic [8:0] wq [4];

    always #10 clk = ~clk;

    rs485_uart_tx #(.CYC_PER_BIT(CPB)) u_rs485_uart_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_en   (cfg_en),
        .cfg_wlen (cfg_wlen),
        .cfg_lead (cfg_lead),
        .cfg_lag  (cfg_lag),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .tx       (tx),
        .de       (de),
        .tx_done  (tx_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(input bit en, input logic [1:0] wl, input int lead, input int lag);
        cfg_wr   = 1'b1;
        cfg_en   = en;
        cfg_wlen = wl;
        cfg_lead = 5'(lead);
        cfg_lag  = 5'(lag);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Disable, load fields while disabled, then enable with a write whose fields are ignored.
    task automatic setup(input logic [1:0] wl, input int lead, input int lag);
        wr_cfg(1'b0, wl, lead, lag);
        wr_cfg(1'b0, wl, lead, lag);
        wr_cfg(1'b1, 2'b01, 31, 31);
    endtask

    function automatic int nbits(input logic [1:0] wl);
        return (wl == 2'b00) ? 8 : (wl == 2'b01) ? 9 : 7;
    endfunction

    task automatic run(input string req, input int n_off, input int n_exp, input int nb,
                       input int lead, input int lag, input int dis_at);
        int l1, fr, t_end, acc, j, f, b;
        int ftx, fde, fdn;
        int atx, etx, ade, ede, adn, edn;
        logic e_tx, e_de, e_dn;
        l1    = lead + 1;
        fr    = (nb + 2) * CPB;
        t_end = l1 + n_exp * fr + lag + 1;
        in_data  = wq[0];
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        acc = 1;
        for (int k = 0; k <= t_end + 1; k++) begin
            @(negedge clk);
            tr_tx[k] = tx;
            tr_de[k] = de;
            tr_dn[k] = tx_done;
            if (k == dis_at) begin
                cfg_wr = 1'b1;
                cfg_en = 1'b0;
            end else begin
                cfg_wr = 1'b0;
            end
            if (acc < n_off) begin
                in_data  = wq[acc];
                in_valid = 1'b1;
                if (in_ready) acc++;
            end else begin
                in_valid = 1'b0;
            end
        end
        in_valid = 1'b0;
        ftx = -1; fde = -1; fdn = -1;
        atx = 0; etx = 0; ade = 0; ede = 0; adn = 0; edn = 0;
        for (int k = 0; k <= t_end + 1; k++) begin
            if (k < l1) begin
                e_tx = 1'b1;
            end else begin
                j = k - l1;
                if (j < n_exp * fr) begin
                    f = j / fr;
                    b = (j % fr) / CPB;
                    if (b == 0)       e_tx = 1'b0;
                    else if (b <= nb) e_tx = wq[f][b-1];
                    else              e_tx = 1'b1;
                end else begin
                    e_tx = 1'b1;
                end
            end
            e_de = (k < t_end);
            e_dn = (k == t_end);
            if (ftx < 0 && tr_tx[k] !== e_tx) begin ftx = k; atx = int'(tr_tx[k]); etx = int'(e_tx); end
            if (fde < 0 && tr_de[k] !== e_de) begin fde = k; ade = int'(tr_de[k]); ede = int'(e_de); end
            if (fdn < 0 && tr_dn[k] !== e_dn) begin fdn = k; adn = int'(tr_dn[k]); edn = int'(e_dn); end
        end
        chk(ftx < 0, req, $sformatf("tx trace at cycle %0d", ftx), atx, etx);
        chk(fde < 0, req, $sformatf("de trace at cycle %0d", fde), ade, ede);
        chk(fdn < 0, req, $sformatf("tx_done trace at cycle %0d", fdn), adn, edn);
        chk(acc == n_exp, req, "words accepted", acc, n_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int leads [5];
        int lags  [4];
        leads = '{0, 1, 2, 17, 31};
        lags  = '{0, 1, 9, 31};
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_en = 1'b0; cfg_wlen = '0;
        cfg_lead = '0; cfg_lag = '0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(tx == 1'b1, "R1", "tx after reset", int'(tx), 1);
        chk(de == 1'b0, "R1", "de after reset", int'(de), 0);
        chk(tx_done == 1'b0, "R1", "tx_done after reset", int'(tx_done), 0);
        chk(in_ready == 1'b0, "R7", "in_ready while disabled", int'(in_ready), 0);

        // R1 default fields: enabling write must not load its fields (R8)
        wr_cfg(1'b1, 2'b01, 31, 31);
        chk(in_ready == 1'b1, "R7", "in_ready when enabled and idle", int'(in_ready), 1);
        wq[0] = 9'h1A5;
        run("R1 defaults", 1, 1, 8, 0, 0, -1);

        // R8: fields written in the disabling write are dropped
        wr_cfg(1'b0, 2'b10, 9, 9);
        chk(in_ready == 1'b0, "R7", "in_ready after disable", int'(in_ready), 0);
        wr_cfg(1'b1, 2'b10, 9, 9);
        wq[0] = 9'h0C3;
        run("R8 lock", 1, 1, 8, 0, 0, -1);

        // R8: fields load only while disabled; then enabled writes are ignored
        setup(2'b00, 3, 2);
        wr_cfg(1'b1, 2'b01, 20, 20);
        wq[0] = 9'h05A;
        run("R8 frozen", 1, 1, 8, 3, 2, -1);

        // R2 R3 R4 R5 sweep over codes and delays
        for (int wl = 0; wl < 4; wl++) begin
            for (int li = 0; li < 5; li++) begin
                for (int gi = 0; gi < 4; gi++) begin
                    setup(2'(wl), leads[li], lags[gi]);
                    wq[0] = 9'((wl * 83 + leads[li] * 7 + lags[gi] * 13 + 9'h15A) ^ (li << 6));
                    run("R2 R3 R4 R5 frame", 1, 1, nbits(2'(wl)), leads[li], lags[gi], -1);
                end
            end
        end

        // R6 back-to-back frames
        for (int wl = 0; wl < 4; wl++) begin
            for (int li = 0; li < 2; li++) begin
                for (int gi = 0; gi < 2; gi++) begin
                    setup(2'(wl), li * 7, gi * 5);
                    for (int w = 0; w < 3; w++) begin
                        wq[w] = 9'(wl * 37 + w * 149 + li * 11 + gi * 3 + 9'h0F1);
                    end
                    run("R6 back-to-back", 3, 3, nbits(2'(wl)), li * 7, gi * 5, -1);
                end
            end
        end

        // R10 idle line after traffic
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(tx == 1'b1 && de == 1'b0, "R10", "idle tx/de", int'({tx, de}), 2);
        end

        // R9 disable during data with a second word pending
        setup(2'b00, 2, 4);
        wq[0] = 9'h0B6;
        wq[1] = 9'h149;
        run("R9 disable mid-frame", 2, 1, 8, 2, 4, 3 + 2 * CPB);
        in_valid = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R9", "in_ready after disabled frame", int'(in_ready), 0);
        chk(de == 1'b0, "R9", "de stays low with word pending", int'(de), 0);
        in_valid = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule